// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Gate

This block sits at the decode stage of an in-order core that has two integer pipes. The primary pipe accepts any integer instruction. The secondary pipe accepts only simple ones. Decoded descriptors arrive on two input lanes, lane 0 being the older of the two. They are held in a two-entry issue window: slot 0 feeds the primary pipe and slot 1 feeds the secondary pipe. In each cycle the gate looks at the window. It either sends both entries down the two pipes together or sends only slot 0.

Each descriptor carries the following fields:

- a tag
- a destination register index
- two source register indices
- a floating-point flag
- a displacement flag
- an immediate flag
- a complex flag

A stall from either pipe holds the whole window. The input lanes use valid/ready, and their readiness tracks how many slots will be free at the next clock edge.

Top module: `dual_issue_pairer`

## Requirements
- R1: After reset both slots are empty. Nothing is issued (`iss_pair` = 0, `iss_single` = 0), and `in_ready` = 2'b11.
- R2: When both slots are valid, no stall is present and the pair is legal, `iss_pair` = 1. `pri_tag` then shows the slot-0 tag and `sec_tag` shows the slot-1 tag. Both entries leave the window at that edge.
- R3: A pair is refused (`iss_single` = 1 instead) when the slot-0 destination is non-zero and equals a slot-1 source or the slot-1 destination.
- R4: Register index 0 means "no register", so a zero slot-0 destination never creates a dependency.
- R5: A displacement or immediate flag on either slot refuses the pair.
- R6: A floating-point flag that differs between the two slots refuses the pair. Two floating-point entries, or two integer entries, may pair.
- R7: A complex flag on slot 1 refuses the pair. A complex flag on slot 0 does not.
- R8: While `stall_pri` or `stall_sec` is high, nothing is issued and both slots keep their contents.
- R9: On single issue, slot 1 moves into slot 0 at the clock edge. Issue order always equals arrival order, with lane 0 ahead of lane 1.
- R10: `in_ready[0]` is high when at least one slot will be free after this cycle's issue. `in_ready[1]` is high when both will be free. Lane 1 is taken only together with lane 0.
- R11: An empty slot is never issued. With only slot 0 valid and no stall, `iss_single` = 1. With slot 0 empty, neither issue output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per-lane descriptor valid; lane 0 is the older |
| in_ready | output | 2 | Per-lane ready |
| in_tag | input | 2xTW | Per-lane tag |
| in_dst | input | 2xRW | Per-lane destination register (0 = none) |
| in_src_a | input | 2xRW | Per-lane first source register (0 = none) |
| in_src_b | input | 2xRW | Per-lane second source register (0 = none) |
| in_fp | input | 2 | Per-lane floating-point flag |
| in_disp | input | 2 | Per-lane displacement flag |
| in_imm | input | 2 | Per-lane immediate flag |
| in_cplx | input | 2 | Per-lane complex flag |
| stall_pri | input | 1 | Stall from the primary pipe |
| stall_sec | input | 1 | Stall from the secondary pipe |
| iss_pair | output | 1 | Both slots issue this cycle |
| iss_single | output | 1 | Only slot 0 issues this cycle |
| pri_tag | output | TW | Tag held in slot 0 |
| sec_tag | output | TW | Tag held in slot 1 |

## Verification
A wrong pairing decision is visible in the same cycle the window holds the offending pair, through `iss_pair` and `iss_single`. A slot that is lost, duplicated or shifted wrongly shows up as a break in the order of issued tags. This appears at `pri_tag` or `sec_tag` within one or two cycles. A window that fails to hold through a stall shows a changed `pri_tag` on the cycle after the stall begins. A wrong free-slot count shows immediately on `in_ready`.

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer #(
  parameter int RW = 5,
  parameter int TW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           in_valid,
  output logic [1:0]           in_ready,
  input  logic [1:0][TW-1:0]   in_tag,
  input  logic [1:0][RW-1:0]   in_dst,
  input  logic [1:0][RW-1:0]   in_src_a,
  input  logic [1:0][RW-1:0]   in_src_b,
  input  logic [1:0]           in_fp,
  input  logic [1:0]           in_disp,
  input  logic [1:0]           in_imm,
  input  logic [1:0]           in_cplx,
  input  logic                 stall_pri,
  input  logic                 stall_sec,
  output logic                 iss_pair,
  output logic                 iss_single,
  output logic [TW-1:0]        pri_tag,
  output logic [TW-1:0]        sec_tag
);
  typedef struct packed {
    logic [TW-1:0] tag;
    logic [RW-1:0] dst;
    logic [RW-1:0] sa;
    logic [RW-1:0] sb;
    logic          fp;
    logic          disp;
    logic          imm;
    logic          cplx;
  } ins_t;

  ins_t s0, s1, ln0, ln1;
  logic v0, v1;
  logic stall, dep, clean, can_pair, acc0, acc1;
  logic [1:0] kept;

  assign ln0 = {in_tag[0], in_dst[0], in_src_a[0], in_src_b[0],
                in_fp[0], in_disp[0], in_imm[0], in_cplx[0]};
  assign ln1 = {in_tag[1], in_dst[1], in_src_a[1], in_src_b[1],
                in_fp[1], in_disp[1], in_imm[1], in_cplx[1]};

  assign stall    = stall_pri | stall_sec;
  assign dep      = (s0.dst != '0) &&
                    (s0.dst == s1.sa || s0.dst == s1.sb || s0.dst == s1.dst);
  assign clean    = !(s0.disp | s0.imm | s1.disp | s1.imm);
  assign can_pair = v1 && !dep && clean && (s0.fp == s1.fp) && !s1.cplx;

  assign iss_pair   = v0 & can_pair & !stall;
  assign iss_single = v0 & !can_pair & !stall;
  assign pri_tag    = s0.tag;
  assign sec_tag    = s1.tag;

  always_comb begin
    if (stall)           kept = {1'b0, v0} + {1'b0, v1};
    else if (iss_single) kept = {1'b0, v1};
    else                 kept = 2'd0;
  end

  assign in_ready[0] = (kept != 2'd2);
  assign in_ready[1] = (kept == 2'd0);
  assign acc0 = in_valid[0] & in_ready[0];
  assign acc1 = in_valid[1] & in_ready[1] & acc0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
      s0 <= '0;
      s1 <= '0;
    end else begin
      case (kept)
        2'd2: ;
        2'd1: begin
          if (!stall) s0 <= s1;
          v0 <= 1'b1;
          v1 <= acc0;
          if (acc0) s1 <= ln0;
        end
        default: begin
          v0 <= acc0;
          v1 <= acc1;
          if (acc0) s0 <= ln0;
          if (acc1) s1 <= ln1;
        end
      endcase
    end
  end
endmodule

module dual_issue_pairer_chk #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          v0,
  input logic          v1,
  input logic          iss_pair,
  input logic          iss_single,
  input logic [TW-1:0] pri_tag,
  input logic [TW-1:0] sec_tag,
  input logic [1:0]    in_ready,
  input logic          sec_cplx,
  input logic          fp_mix
);
  // R2
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_pair && iss_single));
  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !iss_pair && !iss_single);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && v0) |=> v0 && pri_tag == $past(pri_tag));
  // R9
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_single && v1) |=> v0 && pri_tag == $past(sec_tag));
  // R10
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[1] |-> in_ready[0]);
  // R7
  cplx_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_pair |-> !sec_cplx);
  // R6
  fp_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_pair |-> !fp_mix);
  // R11
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v0 |-> !iss_pair && !iss_single);
endmodule

bind dual_issue_pairer dual_issue_pairer_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .v0(v0), .v1(v1),
  .iss_pair(iss_pair), .iss_single(iss_single), .pri_tag(pri_tag),
  .sec_tag(sec_tag), .in_ready(in_ready), .sec_cplx(s1.cplx),
  .fp_mix(s0.fp ^ s1.fp)
);

// File: tb/dual_issue_pairer_tb.sv
module dual_issue_pairer_tb_top;
  localparam int RW = 5;
  localparam int TW = 4;

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [RW-1:0] dst, sa, sb;
    logic fp, disp, imm, cplx;
  } d_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  d_t lane0, lane1;
  logic [1:0] lv = 2'b00;
  logic sp = 1'b0, ss = 1'b0;
  logic [1:0] in_ready;
  logic iss_pair, iss_single;
  logic [TW-1:0] pri_tag, sec_tag;

  dual_issue_pairer #(.RW(RW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(lv), .in_ready(in_ready),
    .in_tag({lane1.tag, lane0.tag}), .in_dst({lane1.dst, lane0.dst}),
    .in_src_a({lane1.sa, lane0.sa}), .in_src_b({lane1.sb, lane0.sb}),
    .in_fp({lane1.fp, lane0.fp}), .in_disp({lane1.disp, lane0.disp}),
    .in_imm({lane1.imm, lane0.imm}), .in_cplx({lane1.cplx, lane0.cplx}),
    .stall_pri(sp), .stall_sec(ss), .iss_pair(iss_pair),
    .iss_single(iss_single), .pri_tag(pri_tag), .sec_tag(sec_tag));

  int total = 0, bad = 0;
  bit done = 0;
  d_t m0, m1;
  bit mv0 = 0, mv1 = 0;
  logic [TW-1:0] ntag = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit legal(d_t a, d_t b);
    bit dep = a.dst != 0 && (a.dst == b.sa || a.dst == b.sb || a.dst == b.dst);
    return !dep && !(a.disp | a.imm | b.disp | b.imm) && a.fp == b.fp && !b.cplx;
  endfunction

  function automatic string why(d_t a, d_t b);
    if (a.dst != 0 && (a.dst == b.sa || a.dst == b.sb || a.dst == b.dst)) return "R3";
    if (a.disp | a.imm | b.disp | b.imm) return "R5";
    if (a.fp != b.fp) return "R6";
    if (b.cplx) return "R7";
    if (a.dst == 0) return "R4";
    return "R2";
  endfunction

  function automatic d_t mk(int dst, int sa, int sb, bit fp, bit disp, bit imm, bit cplx);
    d_t d;
    d.tag = ntag; ntag = ntag + 1'b1;
    d.dst = RW'(dst); d.sa = RW'(sa); d.sb = RW'(sb);
    d.fp = fp; d.disp = disp; d.imm = imm; d.cplx = cplx;
    return d;
  endfunction

  function automatic d_t rnd();
    return mk($urandom % 4, $urandom % 4, $urandom % 4, ($urandom % 4) == 0,
              ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0);
  endfunction

  task automatic step();
    bit st, ep, es, acc0, acc1;
    int k;
    d_t q[2];
    string rq;
    #1;
    st = sp | ss;
    ep = mv0 && mv1 && legal(m0, m1) && !st;
    es = mv0 && !(mv1 && legal(m0, m1)) && !st;
    rq = st ? "R8" : (!mv0 ? "R11" : (!mv1 ? "R11" : why(m0, m1)));
    chk(iss_pair == ep, rq, iss_pair, ep);
    chk(iss_single == es, rq, iss_single, es);
    if (ep || es) chk(pri_tag == m0.tag, "R9", pri_tag, m0.tag);
    if (ep) chk(sec_tag == m1.tag, "R2", sec_tag, m1.tag);
    k = 0;
    if (st) begin
      if (mv0) begin q[k] = m0; k++; end
      if (mv1) begin q[k] = m1; k++; end
    end else if (es && mv1) begin
      q[0] = m1; k = 1;
    end
    chk(in_ready == {k == 0, k < 2}, "R10", in_ready, {k == 0, k < 2});
    acc0 = lv[0] && k < 2;
    acc1 = lv[1] && acc0 && k == 0;
    if (acc0) begin q[k] = lane0; k++; end
    if (acc1) begin q[k] = lane1; k++; end
    @(posedge clk);
    mv0 = k > 0; mv1 = k > 1; m0 = q[0]; m1 = q[1];
    @(negedge clk);
  endtask

  task automatic drain();
    lv = 2'b00; sp = 0; ss = 0;
    for (int i = 0; i < 3; i++) step();
  endtask

  task automatic try_pair(d_t a, d_t b);
    drain();
    lane0 = a; lane1 = b; lv = 2'b11;
    step();
    lv = 2'b00;
    step();
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    lane0 = mk(1, 2, 3, 0, 0, 0, 0); lane1 = mk(4, 5, 6, 0, 0, 0, 0);
    lv = 2'b11;
    repeat (3) @(negedge clk);
    lv = 2'b00;
    rst_n = 1'b1;
    #1;
    chk(iss_pair == 0, "R1", iss_pair, 0);
    chk(iss_single == 0, "R1", iss_single, 0);
    chk(in_ready == 2'b11, "R1", in_ready, 3);
    @(negedge clk);

    try_pair(mk(1, 2, 3, 0, 0, 0, 0), mk(4, 5, 6, 0, 0, 0, 0));   // R2
    try_pair(mk(1, 2, 3, 0, 0, 0, 0), mk(4, 1, 6, 0, 0, 0, 0));   // R3 src a
    try_pair(mk(2, 2, 3, 0, 0, 0, 0), mk(4, 5, 2, 0, 0, 0, 0));   // R3 src b
    try_pair(mk(3, 1, 1, 0, 0, 0, 0), mk(3, 5, 6, 0, 0, 0, 0));   // R3 same dst
    try_pair(mk(0, 1, 2, 0, 0, 0, 0), mk(0, 0, 0, 0, 0, 0, 0));   // R4
    try_pair(mk(1, 2, 3, 0, 1, 0, 0), mk(4, 5, 6, 0, 0, 0, 0));   // R5
    try_pair(mk(1, 2, 3, 0, 0, 0, 0), mk(4, 5, 6, 0, 0, 1, 0));   // R5
    try_pair(mk(1, 2, 3, 1, 0, 0, 0), mk(4, 5, 6, 0, 0, 0, 0));   // R6 mix
    try_pair(mk(1, 2, 3, 1, 0, 0, 0), mk(4, 5, 6, 1, 0, 0, 0));   // R6 fp pair
    try_pair(mk(1, 2, 3, 0, 0, 0, 0), mk(4, 5, 6, 0, 0, 0, 1));   // R7 sec
    try_pair(mk(1, 2, 3, 0, 0, 0, 1), mk(4, 5, 6, 0, 0, 0, 0));   // R7 pri ok

    drain();                                                       // R8
    lane0 = mk(1, 2, 3, 0, 0, 0, 0); lane1 = mk(4, 5, 6, 0, 0, 0, 0);
    lv = 2'b11; step();
    lv = 2'b11; sp = 1; lane0 = mk(7, 0, 0, 0, 0, 0, 0); lane1 = mk(8, 0, 0, 0, 0, 0, 0);
    step(); step();
    sp = 0; ss = 1; step();
    ss = 0; lv = 2'b00; step(); step();

    drain();                                                       // R11
    lane0 = mk(1, 2, 3, 0, 0, 0, 0); lv = 2'b01; step();
    lv = 2'b00; step(); step();

    for (int i = 0; i < 4000; i++) begin
      lane0 = rnd(); lane1 = rnd();
      lv = 2'($urandom % 4);
      sp = ($urandom % 5) == 0;
      ss = ($urandom % 7) == 0;
      step();
    end
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule